// File: doc/BRIEF.md
# Five-State Snooping Coherence Controller

This block keeps the coherence state of every line of a small direct-mapped cache that shares a snooping bus with other caches. Each line is Modified, Exclusive, Recent, Shared or Invalid. Recent is a clean copy that is the only valid copy anywhere. Unlike Exclusive, a Recent line has to win an ownership transaction on the bus before it may be written. The block holds only tags and states. Data movement is reported through response flags and is not carried.

The local side accepts one read or write request at a time. It answers hits without the bus. For anything else it raises a bus request with a command (read, read-for-ownership or upgrade) and holds it until the arbiter grants it. The grant cycle is also the cycle in which the other caches snoop the transaction and drive their combined shared and handoff responses back. The snoop side answers another cache's transaction in the same cycle. A peek port shows the state and tag of any line so that a system-level checker can verify the rules between caches.

Top module: `coh5_ctrl`

## Requirements
- R1: After reset every line is Invalid (state code I=0, S=1, E=2, R=3, M=4), `cpu_ready` is high and `bus_req` is low. A line never holds a code above 4.
- R2: A read that misses issues bus command READ (code 1). At the grant the line is filled as Recent if `bus_rsp_handoff` is high. Otherwise it is filled as Shared if `bus_rsp_shared` is high, and as Exclusive if neither is high.
- R3: A read that hits a valid line with a matching tag completes with no bus request and leaves the state unchanged.
- R4: A write to a Recent line issues UPGRADE (code 3). The line becomes Modified only in the grant cycle.
- R5: A write to an Exclusive line moves it to Modified with no bus transaction. A write to a Modified line uses no bus either.
- R6: A write to a Shared line issues UPGRADE. A write to an Invalid line, or to a line with another tag, issues READ-FOR-OWNERSHIP (code 2). In both cases the line becomes Modified at the grant.
- R7: A snooped READ that hits a line works as follows. Exclusive or Shared gives `snp_shared`, and the line ends up Shared. With MIGRATE=0, Modified gives `snp_dirty` and `snp_shared`, and Recent gives `snp_shared`; both end Shared. With MIGRATE=1, Modified gives `snp_dirty` and `snp_handoff`, and Recent gives `snp_handoff`; both end Invalid. `snp_shared` and `snp_handoff` are never high together.
- R8: A snooped READ-FOR-OWNERSHIP or UPGRADE that hits a valid line invalidates it, and raises `snp_dirty` if the line was Modified.
- R9: A snoop whose tag does not match, or that hits an Invalid line, raises no response and changes no state.
- R10: A fill that replaces a Modified line of another tag raises `victim_wb` in the grant cycle.
- R11: Across caches on one bus, a line held Modified, Exclusive or Recent in one cache is Invalid in every other cache. A Shared line coexists only with Shared or Invalid copies.
- R12: `bus_req` stays high with a stable `bus_addr` until `bus_gnt`, and `cpu_done` pulses in the cycle after the grant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req_valid | input | 1 | Local request, taken when `cpu_ready` is high |
| cpu_req_write | input | 1 | 1 = write, 0 = read |
| cpu_req_addr | input | ADDR_W | Line address of the request |
| cpu_ready | output | 1 | Controller idle and able to take a request |
| cpu_done | output | 1 | One-cycle pulse when a request completes |
| bus_req | output | 1 | Bus transaction wanted |
| bus_cmd | output | 2 | 0 none, 1 READ, 2 READ-FOR-OWNERSHIP, 3 UPGRADE |
| bus_addr | output | ADDR_W | Address of the bus transaction |
| bus_gnt | input | 1 | Grant; the transaction completes in this cycle |
| bus_rsp_shared | input | 1 | OR of the other caches' shared responses |
| bus_rsp_handoff | input | 1 | OR of the other caches' handoff responses |
| victim_wb | output | 1 | A dirty victim is written back at this fill |
| snp_valid | input | 1 | Another cache's transaction is visible |
| snp_cmd | input | 2 | Command of the snooped transaction |
| snp_addr | input | ADDR_W | Address of the snooped transaction |
| snp_shared | output | 1 | This cache keeps a clean shared copy |
| snp_dirty | output | 1 | This cache supplies modified data |
| snp_handoff | output | 1 | This cache supplies the line and drops it |
| peek_idx | input | IDX_W | Line index to observe |
| peek_state | output | 3 | State code of the observed line |
| peek_tag | output | TAG_W | Tag of the observed line |

## Verification
The bench puts three controllers with 8 lines and 8-bit addresses on one modelled bus. Two are built with MIGRATE=1 and one with MIGRATE=0. The mix means that a single access sequence reaches both snooped-read behaviours for Modified and Recent lines. It also lets the Recent state be created by a handoff and then lost to a plain shared read. Two tags that map to the same index reach dirty-victim replacement, and two tags that share the other index reach snoop tag misses. After every transaction, every line is checked for pairwise compatibility across the three caches.

// File: rtl/coh5_pkg.sv
package coh5_pkg;

   typedef enum logic [2:0] {
      ST_I = 3'd0,
      ST_S = 3'd1,
      ST_E = 3'd2,
      ST_R = 3'd3,
      ST_M = 3'd4
   } line_st_t;

   typedef enum logic [1:0] {
      CMD_NONE = 2'd0,
      CMD_READ = 2'd1,
      CMD_RFO  = 2'd2,
      CMD_UPG  = 2'd3
   } bus_cmd_t;

endpackage

// File: rtl/coh5_line_store.sv
module coh5_line_store
   import coh5_pkg::*;
#(
   parameter int LINES = 8,
   parameter int TAG_W = 5,
   parameter int NRD   = 3,
   localparam int IDX_W = $clog2(LINES)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [IDX_W-1:0] rd_idx [NRD],
   output line_st_t         rd_st  [NRD],
   output logic [TAG_W-1:0] rd_tag [NRD],
   input  logic             loc_we,
   input  logic [IDX_W-1:0] loc_idx,
   input  logic [TAG_W-1:0] loc_tag,
   input  line_st_t         loc_st,
   input  logic             snp_we,
   input  logic [IDX_W-1:0] snp_idx,
   input  line_st_t         snp_st
);

   line_st_t         st_q  [LINES];
   logic [TAG_W-1:0] tag_q [LINES];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < LINES; i++) begin
            st_q[i]  <= ST_I;
            tag_q[i] <= '0;
         end
      end else begin
         if (loc_we) begin
            st_q[loc_idx]  <= loc_st;
            tag_q[loc_idx] <= loc_tag;
         end
         if (snp_we) st_q[snp_idx] <= snp_st;
      end
   end

   for (genvar p = 0; p < NRD; p++) begin : g_rd
      assign rd_st[p]  = st_q[rd_idx[p]];
      assign rd_tag[p] = tag_q[rd_idx[p]];

      // R1: no line ever carries an undefined state code
      a_r1_state_legal: assert property (@(posedge clk) disable iff (!rst_n)
         rd_st[p] inside {ST_I, ST_S, ST_E, ST_R, ST_M});
   end

endmodule

// File: rtl/coh5_snoop.sv
module coh5_snoop
   import coh5_pkg::*;
#(
   parameter bit MIGRATE = 1'b1
) (
   input  logic     clk,
   input  logic     rst_n,
   input  logic     snp_valid,
   input  bus_cmd_t snp_cmd,
   input  logic     hit,
   input  line_st_t cur_st,
   output logic     rsp_shared,
   output logic     rsp_dirty,
   output logic     rsp_handoff,
   output logic     upd,
   output line_st_t nxt_st
);

   // reaction of an owned line (M or R) to a remote read: variant by parameter
   logic     own_share, own_hand;
   line_st_t own_next;

   if (MIGRATE) begin : g_migrate
      assign own_share = 1'b0;
      assign own_hand  = 1'b1;
      assign own_next  = ST_I;
   end else begin : g_keep
      assign own_share = 1'b1;
      assign own_hand  = 1'b0;
      assign own_next  = ST_S;
   end

   always_comb begin
      rsp_shared  = 1'b0;
      rsp_dirty   = 1'b0;
      rsp_handoff = 1'b0;
      upd         = 1'b0;
      nxt_st      = cur_st;
      if (snp_valid && hit) begin
         if (snp_cmd == CMD_READ) begin
            unique case (cur_st)
               ST_M: begin
                  rsp_dirty   = 1'b1;
                  rsp_shared  = own_share;
                  rsp_handoff = own_hand;
                  upd         = 1'b1;
                  nxt_st      = own_next;
               end
               ST_R: begin
                  rsp_shared  = own_share;
                  rsp_handoff = own_hand;
                  upd         = 1'b1;
                  nxt_st      = own_next;
               end
               ST_E: begin
                  rsp_shared = 1'b1;
                  upd        = 1'b1;
                  nxt_st     = ST_S;
               end
               ST_S: rsp_shared = 1'b1;
               default: ;
            endcase
         end else if (snp_cmd == CMD_RFO || snp_cmd == CMD_UPG) begin
            rsp_dirty = (cur_st == ST_M);
            upd       = 1'b1;
            nxt_st    = ST_I;
         end
      end
   end

   // R7: a requester never sees both a sharing and a handoff answer from one cache
   a_r7_single_answer: assert property (@(posedge clk) disable iff (!rst_n)
      !(rsp_shared && rsp_handoff));

endmodule

// File: rtl/coh5_req_fsm.sv
module coh5_req_fsm
   import coh5_pkg::*;
#(
   parameter int ADDR_W = 8,
   parameter int IDX_W  = 3,
   localparam int TAG_W = ADDR_W - IDX_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cpu_req_valid,
   input  logic              cpu_req_write,
   input  logic [ADDR_W-1:0] cpu_req_addr,
   output logic              cpu_ready,
   output logic              cpu_done,
   output logic [IDX_W-1:0]  look_idx,
   input  line_st_t          look_st,
   input  logic [TAG_W-1:0]  look_tag,
   input  logic              snp_valid,
   input  logic [IDX_W-1:0]  snp_idx,
   output logic              bus_req,
   output bus_cmd_t          bus_cmd,
   output logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_gnt,
   input  logic              rsp_shared,
   input  logic              rsp_handoff,
   output logic              victim_wb,
   output logic              loc_we,
   output logic [IDX_W-1:0]  loc_idx,
   output logic [TAG_W-1:0]  loc_tag,
   output line_st_t          loc_st
);

   typedef enum logic [1:0] {FS_IDLE, FS_CHECK, FS_BUS} fs_t;

   fs_t               fs_q;
   logic [ADDR_W-1:0] addr_q;
   logic              wr_q;
   logic              done_q;

   logic     hit, need_bus, conflict;
   bus_cmd_t want_cmd;

   assign look_idx = addr_q[IDX_W-1:0];
   assign loc_idx  = addr_q[IDX_W-1:0];
   assign loc_tag  = addr_q[ADDR_W-1:IDX_W];
   assign hit      = (look_st != ST_I) && (look_tag == loc_tag);
   assign need_bus = wr_q ? !(hit && (look_st == ST_M || look_st == ST_E)) : !hit;
   assign want_cmd = !wr_q ? CMD_READ :
                     (hit && (look_st == ST_S || look_st == ST_R)) ? CMD_UPG : CMD_RFO;
   assign conflict = snp_valid && (snp_idx == look_idx);

   assign cpu_ready = (fs_q == FS_IDLE);
   assign cpu_done  = done_q;
   assign bus_req   = (fs_q == FS_BUS);
   assign bus_cmd   = bus_req ? want_cmd : CMD_NONE;
   assign bus_addr  = addr_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         fs_q   <= FS_IDLE;
         addr_q <= '0;
         wr_q   <= 1'b0;
         done_q <= 1'b0;
      end else begin
         done_q <= 1'b0;
         unique case (fs_q)
            FS_IDLE: if (cpu_req_valid) begin
               addr_q <= cpu_req_addr;
               wr_q   <= cpu_req_write;
               fs_q   <= FS_CHECK;
            end
            FS_CHECK: if (!conflict) begin
               if (need_bus) fs_q <= FS_BUS;
               else begin
                  fs_q   <= FS_IDLE;
                  done_q <= 1'b1;
               end
            end
            FS_BUS: if (bus_gnt) begin
               fs_q   <= FS_IDLE;
               done_q <= 1'b1;
            end
            default: fs_q <= FS_IDLE;
         endcase
      end
   end

   always_comb begin
      loc_we    = 1'b0;
      loc_st    = look_st;
      victim_wb = 1'b0;
      if (fs_q == FS_CHECK && !conflict && !need_bus && wr_q && look_st == ST_E) begin
         loc_we = 1'b1;
         loc_st = ST_M;
      end else if (fs_q == FS_BUS && bus_gnt) begin
         loc_we    = 1'b1;
         loc_st    = wr_q ? ST_M : rsp_handoff ? ST_R : rsp_shared ? ST_S : ST_E;
         victim_wb = !hit && (look_st == ST_M);
      end
   end

   // R12: a pending request is held steady until granted
   a_r12_req_held: assert property (@(posedge clk) disable iff (!rst_n)
      bus_req && !bus_gnt |=> bus_req && $stable(bus_addr));

   // R12: completion follows the grant by one cycle
   a_r12_done_after_grant: assert property (@(posedge clk) disable iff (!rst_n)
      bus_req && bus_gnt |=> cpu_done);

endmodule

// File: rtl/coh5_ctrl.sv
module coh5_ctrl
   import coh5_pkg::*;
#(
   parameter int N_LINES = 8,
   parameter int ADDR_W  = 8,
   parameter bit MIGRATE = 1'b1,
   localparam int IDX_W  = $clog2(N_LINES),
   localparam int TAG_W  = ADDR_W - IDX_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cpu_req_valid,
   input  logic              cpu_req_write,
   input  logic [ADDR_W-1:0] cpu_req_addr,
   output logic              cpu_ready,
   output logic              cpu_done,
   output logic              bus_req,
   output logic [1:0]        bus_cmd,
   output logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_gnt,
   input  logic              bus_rsp_shared,
   input  logic              bus_rsp_handoff,
   output logic              victim_wb,
   input  logic              snp_valid,
   input  logic [1:0]        snp_cmd,
   input  logic [ADDR_W-1:0] snp_addr,
   output logic              snp_shared,
   output logic              snp_dirty,
   output logic              snp_handoff,
   input  logic [IDX_W-1:0]  peek_idx,
   output logic [2:0]        peek_state,
   output logic [TAG_W-1:0]  peek_tag
);

   if (N_LINES < 2 || (N_LINES & (N_LINES - 1)) != 0) begin : g_bad_lines
      $error("coh5_ctrl: N_LINES must be a power of two of at least 2");
   end
   if (ADDR_W <= IDX_W) begin : g_bad_addr
      $error("coh5_ctrl: ADDR_W must leave at least one tag bit");
   end

   localparam int RD_REQ  = 0;
   localparam int RD_SNP  = 1;
   localparam int RD_PEEK = 2;
   localparam int NRD     = 3;

   logic [IDX_W-1:0] rd_idx [NRD];
   line_st_t         rd_st  [NRD];
   logic [TAG_W-1:0] rd_tag [NRD];

   logic             loc_we;
   logic [IDX_W-1:0] loc_idx;
   logic [TAG_W-1:0] loc_tag;
   line_st_t         loc_st;
   logic             snp_we;
   line_st_t         snp_nxt;
   bus_cmd_t         req_cmd;
   logic             snp_hit;
   logic [IDX_W-1:0] req_idx;

   assign rd_idx[RD_REQ]  = req_idx;
   assign rd_idx[RD_SNP]  = snp_addr[IDX_W-1:0];
   assign rd_idx[RD_PEEK] = peek_idx;
   assign snp_hit    = (rd_st[RD_SNP] != ST_I) && (rd_tag[RD_SNP] == snp_addr[ADDR_W-1:IDX_W]);
   assign bus_cmd    = req_cmd;
   assign peek_state = rd_st[RD_PEEK];
   assign peek_tag   = rd_tag[RD_PEEK];

   coh5_line_store #(.LINES(N_LINES), .TAG_W(TAG_W), .NRD(NRD)) store_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .rd_idx  (rd_idx),
      .rd_st   (rd_st),
      .rd_tag  (rd_tag),
      .loc_we  (loc_we),
      .loc_idx (loc_idx),
      .loc_tag (loc_tag),
      .loc_st  (loc_st),
      .snp_we  (snp_we),
      .snp_idx (snp_addr[IDX_W-1:0]),
      .snp_st  (snp_nxt)
   );

   coh5_snoop #(.MIGRATE(MIGRATE)) snoop_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .snp_valid   (snp_valid),
      .snp_cmd     (bus_cmd_t'(snp_cmd)),
      .hit         (snp_hit),
      .cur_st      (rd_st[RD_SNP]),
      .rsp_shared  (snp_shared),
      .rsp_dirty   (snp_dirty),
      .rsp_handoff (snp_handoff),
      .upd         (snp_we),
      .nxt_st      (snp_nxt)
   );

   coh5_req_fsm #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) fsm_i (
      .clk           (clk),
      .rst_n         (rst_n),
      .cpu_req_valid (cpu_req_valid),
      .cpu_req_write (cpu_req_write),
      .cpu_req_addr  (cpu_req_addr),
      .cpu_ready     (cpu_ready),
      .cpu_done      (cpu_done),
      .look_idx      (req_idx),
      .look_st       (rd_st[RD_REQ]),
      .look_tag      (rd_tag[RD_REQ]),
      .snp_valid     (snp_valid),
      .snp_idx       (snp_addr[IDX_W-1:0]),
      .bus_req       (bus_req),
      .bus_cmd       (req_cmd),
      .bus_addr      (bus_addr),
      .bus_gnt       (bus_gnt),
      .rsp_shared    (bus_rsp_shared),
      .rsp_handoff   (bus_rsp_handoff),
      .victim_wb     (victim_wb),
      .loc_we        (loc_we),
      .loc_idx       (loc_idx),
      .loc_tag       (loc_tag),
      .loc_st        (loc_st)
   );

   // R4: a Recent line becomes Modified only while its bus transaction is granted
   a_r4_recent_needs_grant: assert property (@(posedge clk) disable iff (!rst_n)
      loc_we && loc_st == ST_M && rd_st[RD_REQ] == ST_R && rd_tag[RD_REQ] == loc_tag
      |-> bus_gnt);

   // R5: the Exclusive-to-Modified step happens without any bus request
   a_r5_exclusive_silent: assert property (@(posedge clk) disable iff (!rst_n)
      loc_we && loc_st == ST_M && rd_st[RD_REQ] == ST_E && rd_tag[RD_REQ] == loc_tag
      |-> !bus_req);

endmodule

// File: tb/coh5_ctrl_tb_top.sv
module coh5_ctrl_tb_top;
   import coh5_pkg::*;

   localparam int NC     = 3;
   localparam int ADDR_W = 8;
   localparam int LINES  = 8;
   localparam int IDX_W  = 3;
   localparam int TAG_W  = 5;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #5 clk = ~clk;

   logic              cpu_v   [NC];
   logic              cpu_w   [NC];
   logic [ADDR_W-1:0] cpu_a   [NC];
   logic              rdy     [NC];
   logic              done    [NC];
   logic              breq    [NC];
   logic [1:0]        bcmd    [NC];
   logic [ADDR_W-1:0] baddr   [NC];
   logic              gnt     [NC];
   logic              vwb     [NC];
   logic              snpv    [NC];
   logic              s_sh    [NC];
   logic              s_dt    [NC];
   logic              s_ho    [NC];
   logic [2:0]        pk_st   [NC];
   logic [TAG_W-1:0]  pk_tag  [NC];
   logic [IDX_W-1:0]  peek_idx;
   logic [1:0]        snp_cmd_b;
   logic [ADDR_W-1:0] snp_addr_b;
   logic              rsp_sh, rsp_ho, rsp_dt;
   int                owner;
   logic              any_req;

   for (genvar g = 0; g < NC; g++) begin : gen_c
      coh5_ctrl #(.N_LINES(LINES), .ADDR_W(ADDR_W), .MIGRATE(g != 2)) dut_i (
         .clk (clk), .rst_n (rst_n),
         .cpu_req_valid (cpu_v[g]), .cpu_req_write (cpu_w[g]), .cpu_req_addr (cpu_a[g]),
         .cpu_ready (rdy[g]), .cpu_done (done[g]),
         .bus_req (breq[g]), .bus_cmd (bcmd[g]), .bus_addr (baddr[g]), .bus_gnt (gnt[g]),
         .bus_rsp_shared (rsp_sh), .bus_rsp_handoff (rsp_ho), .victim_wb (vwb[g]),
         .snp_valid (snpv[g]), .snp_cmd (snp_cmd_b), .snp_addr (snp_addr_b),
         .snp_shared (s_sh[g]), .snp_dirty (s_dt[g]), .snp_handoff (s_ho[g]),
         .peek_idx (peek_idx), .peek_state (pk_st[g]), .peek_tag (pk_tag[g])
      );
   end

   // bus model: fixed-priority arbiter, the owner's transaction is snooped by the rest
   always_comb begin
      owner   = 0;
      any_req = 1'b0;
      for (int k = NC - 1; k >= 0; k--) begin
         if (breq[k]) begin
            owner   = k;
            any_req = 1'b1;
         end
      end
      for (int k = 0; k < NC; k++) begin
         gnt[k]  = any_req && (owner == k);
         snpv[k] = any_req && (owner != k);
      end
      snp_cmd_b  = bcmd[owner];
      snp_addr_b = baddr[owner];
   end

   always_comb begin
      rsp_sh = 1'b0;
      rsp_ho = 1'b0;
      rsp_dt = 1'b0;
      for (int k = 0; k < NC; k++) begin
         rsp_sh = rsp_sh | s_sh[k];
         rsp_ho = rsp_ho | s_ho[k];
         rsp_dt = rsp_dt | s_dt[k];
      end
   end

   int   gcnt     [NC];
   logic [1:0] last_cmd [NC];
   logic last_vwb [NC];
   logic last_dirty;

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int k = 0; k < NC; k++) begin
            gcnt[k]     <= 0;
            last_cmd[k] <= 2'd0;
            last_vwb[k] <= 1'b0;
         end
         last_dirty <= 1'b0;
      end else begin
         for (int k = 0; k < NC; k++) begin
            if (gnt[k]) begin
               gcnt[k]     <= gcnt[k] + 1;
               last_cmd[k] <= bcmd[k];
               last_vwb[k] <= vwb[k];
               last_dirty  <= rsp_dt;
            end
         end
      end
   end

   int n_chk  = 0;
   int n_fail = 0;
   bit finished = 1'b0;

   task automatic chk(bit ok, string req, string what, int act, int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   // scoreboard item: what the requesting cache must show when its request completes
   typedef struct {
      int       k;
      int       idx;
      int       tag;
      line_st_t st;
      bus_cmd_t cmd;
      int       g0;
      string    req;
   } item_t;

   item_t sb_q[$];

   // monitor
   always @(negedge clk) begin
      for (int k = 0; k < NC; k++) begin
         if (rst_n && done[k]) begin
            if (sb_q.size() == 0) begin
               chk(1'b0, "R12", "unexpected completion", k, -1);
            end else begin
               item_t it;
               it = sb_q.pop_front();
               chk(it.k == k, it.req, "completing cache", k, it.k);
               chk(pk_st[k] == 3'(it.st), it.req, "requester state", int'(pk_st[k]), int'(it.st));
               chk(int'(pk_tag[k]) == it.tag, it.req, "requester tag", int'(pk_tag[k]), it.tag);
               if (it.cmd == CMD_NONE) begin
                  chk(gcnt[k] == it.g0, it.req, "bus grants used", gcnt[k] - it.g0, 0);
               end else begin
                  chk(gcnt[k] == it.g0 + 1, it.req, "bus grants used", gcnt[k] - it.g0, 1);
                  chk(last_cmd[k] == 2'(it.cmd), it.req, "bus command", int'(last_cmd[k]), int'(it.cmd));
               end
            end
         end
      end
   end

   // driver
   task automatic op(int k, bit wr, logic [ADDR_W-1:0] a, line_st_t st, bus_cmd_t cmd, string req);
      item_t it;
      @(negedge clk);
      peek_idx = a[IDX_W-1:0];
      it.k = k; it.idx = int'(a[IDX_W-1:0]); it.tag = int'(a[ADDR_W-1:IDX_W]);
      it.st = st; it.cmd = cmd; it.g0 = gcnt[k]; it.req = req;
      sb_q.push_back(it);
      cpu_v[k] = 1'b1;
      cpu_w[k] = wr;
      cpu_a[k] = a;
      @(negedge clk);
      cpu_v[k] = 1'b0;
      while (!done[k]) @(negedge clk);
      #1;
   endtask

   task automatic expect_st(int k, logic [ADDR_W-1:0] a, line_st_t st, string req);
      peek_idx = a[IDX_W-1:0];
      #1;
      chk(pk_st[k] == 3'(st), req, $sformatf("cache %0d state", k), int'(pk_st[k]), int'(st));
   endtask

   // R11: pairwise compatibility of every line across all caches
   task automatic sweep();
      for (int i = 0; i < LINES; i++) begin
         peek_idx = IDX_W'(i);
         #1;
         for (int a = 0; a < NC; a++) begin
            for (int b = a + 1; b < NC; b++) begin
               bit both = (pk_st[a] != 3'(ST_I)) && (pk_st[b] != 3'(ST_I)) && (pk_tag[a] == pk_tag[b]);
               bit ok = !both || (pk_st[a] == 3'(ST_S) && pk_st[b] == 3'(ST_S));
               chk(ok, "R11", $sformatf("pair %0d/%0d line %0d", a, b, i),
                   int'(pk_st[a]) * 8 + int'(pk_st[b]), 9);
            end
         end
      end
   endtask

   localparam logic [ADDR_W-1:0] A_ = 8'h12;
   localparam logic [ADDR_W-1:0] B_ = 8'h1A;
   localparam logic [ADDR_W-1:0] C_ = 8'h05;
   localparam logic [ADDR_W-1:0] D_ = 8'h0D;

   task automatic report();
      if (!finished) begin
         finished = 1'b1;
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   endtask

   initial begin
      #2000000;
      chk(1'b0, "R12", "watchdog expired", 0, 1);
      report();
   end

   initial begin
      for (int k = 0; k < NC; k++) begin
         cpu_v[k] = 1'b0; cpu_w[k] = 1'b0; cpu_a[k] = '0;
      end
      peek_idx = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset state
      for (int k = 0; k < NC; k++) begin
         chk(rdy[k] == 1'b1, "R1", "ready after reset", int'(rdy[k]), 1);
         chk(breq[k] == 1'b0, "R1", "no bus request after reset", int'(breq[k]), 0);
         for (int i = 0; i < LINES; i++) begin
            peek_idx = IDX_W'(i);
            #1;
            chk(pk_st[k] == 3'(ST_I), "R1", "line invalid after reset", int'(pk_st[k]), 0);
         end
      end

      op(0, 0, A_, ST_E, CMD_READ, "R2"); sweep();                 // R2 no sharer -> E
      op(0, 0, A_, ST_E, CMD_NONE, "R3"); sweep();                 // R3 read hit
      op(0, 1, A_, ST_M, CMD_NONE, "R5"); sweep();                 // R5 silent E->M
      op(1, 0, A_, ST_R, CMD_READ, "R2"); sweep();                 // R2 handoff -> R
      expect_st(0, A_, ST_I, "R7");                                // R7 migrate M -> I
      chk(last_dirty == 1'b1, "R7", "dirty supply from M", int'(last_dirty), 1);
      op(1, 1, A_, ST_M, CMD_UPG, "R4"); sweep();                  // R4 R needs upgrade
      op(2, 0, A_, ST_R, CMD_READ, "R2"); sweep();
      expect_st(1, A_, ST_I, "R7");
      op(0, 0, A_, ST_S, CMD_READ, "R2"); sweep();                 // non-migrating R shares
      expect_st(2, A_, ST_S, "R7");
      op(1, 0, A_, ST_S, CMD_READ, "R7"); sweep();                 // S answers shared
      expect_st(0, A_, ST_S, "R7");
      expect_st(2, A_, ST_S, "R7");
      op(0, 1, A_, ST_M, CMD_UPG, "R6"); sweep();                  // R6 S -> upgrade
      expect_st(1, A_, ST_I, "R8");
      expect_st(2, A_, ST_I, "R8");
      op(2, 0, A_, ST_R, CMD_READ, "R7"); sweep();
      op(2, 1, A_, ST_M, CMD_UPG, "R4"); sweep();
      op(1, 0, A_, ST_S, CMD_READ, "R7"); sweep();                 // non-migrating M -> S
      expect_st(2, A_, ST_S, "R7");
      chk(last_dirty == 1'b1, "R7", "dirty supply from non-migrating M", int'(last_dirty), 1);
      op(0, 1, A_, ST_M, CMD_RFO, "R6"); sweep();                  // R6 I -> RFO
      expect_st(1, A_, ST_I, "R8");
      expect_st(2, A_, ST_I, "R8");
      op(0, 1, B_, ST_M, CMD_RFO, "R10"); sweep();                 // R10 dirty victim
      chk(last_vwb[0] == 1'b1, "R10", "victim writeback on B fill", int'(last_vwb[0]), 1);
      op(1, 0, C_, ST_E, CMD_READ, "R2"); sweep();
      chk(last_vwb[1] == 1'b0, "R10", "no writeback for clean victim", int'(last_vwb[1]), 0);
      op(2, 0, D_, ST_E, CMD_READ, "R9"); sweep();                 // R9 tag miss, no answer
      expect_st(1, C_, ST_E, "R9");
      op(1, 1, C_, ST_M, CMD_NONE, "R5"); sweep();
      op(0, 0, A_, ST_E, CMD_READ, "R10"); sweep();
      chk(last_vwb[0] == 1'b1, "R10", "victim writeback on read fill", int'(last_vwb[0]), 1);
      chk(sb_q.size() == 0, "R12", "scoreboard drained", sb_q.size(), 0);
      repeat (2) @(negedge clk);
      report();
   end

endmodule